// File: doc/BRIEF.md
# Multi-Block Write Transaction Tracker

This block follows a card-side multiple-block write from the moment the write command is decoded until the card goes back to the transfer state. Upstream logic gives it decoded command events, a strobe for each received data block together with the byte length of that block, a configuration bit that allows misaligned partial blocks, and a flag from an address checker that marks hits on protected regions. The block reports the card state, pulses an illegal-command flag, commits or discards each data block, and keeps the address-error and write-protect-violation status bits.

Two kinds of transfer are supported. A set-count command placed directly in front of the write-multiple command starts a counted write. That write ends by itself after the last counted block. Any other write-multiple starts an open-ended write, which runs until a stop command arrives. When a block breaks alignment or hits a protected region, the tracker sets the matching error bit and stays in the receive state. From then on it drops every later block until a stop arrives, and the stop response carries the error. After a stop, or after the last counted block, the tracker holds a programming state for a set number of cycles before it returns to transfer.

Top module: `mbw_tracker`

## Requirements
- R1: After reset, `state` is 0 (transfer), and `addr_err`, `wp_viol`, `rsp_valid`, `illegal_cmd` and `blk_commit` are all 0. `state` never takes the value 3. State codes: 0 transfer, 1 receive, 2 programming.
- R2: Command codes on `cmd_kind` are 0 other, 1 set-count, 2 write-multiple, 3 stop and 4 status. A write-multiple in the transfer state moves `state` to 1. It starts a counted write only when the command just before it was a set-count with a nonzero argument. Otherwise the write is open-ended.
- R3: In a counted write, the block that completes the count moves `state` to 2 with no stop command. `state` then stays at 2 for `BUSY_CYC` cycles and returns to 0.
- R4: A stop received while `state` is 0 or 2 pulses `illegal_cmd` for one cycle. It produces no response and leaves `state` unchanged.
- R5: An open-ended write accepts any number of blocks and stays in state 1. A stop in state 1 ends either write type: it raises `rsp_valid` and moves `state` to 2.
- R6: A set-count with argument 0, followed by a write-multiple, gives an open-ended write.
- R7: When `misalign_ok` is 0 and the running byte offset inside a `BLK_BYTES` block is nonzero at the arrival of a block, that block is discarded and `addr_err` is set. `state` stays 1, and every later block is discarded until a stop.
- R8: A block that arrives with `wp_hit` high is discarded and sets `wp_viol`, with the same halt and discard behaviour as R7. This holds even when the block would have completed a counted write.
- R9: A stop in state 1, or a status command in any state, raises `rsp_valid` for one cycle. `rsp_addr_err` and `rsp_wp_viol` carry the error bits as they stood, and both error bits clear in that same cycle.
- R10: With `misalign_ok` at 1, partial blocks of any length are committed, which is shown by one `blk_commit` pulse per block.
- R11: A block is committed only in state 1 and only when no command is present in the same cycle. Each committed block gives a one-cycle `blk_commit` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present |
| cmd_kind | input | 3 | Command code (see R2) |
| cmd_arg | input | CNT_W | Block count for set-count |
| blk_valid | input | 1 | A data block has been received |
| blk_len | input | LEN_W | Byte length of the received block |
| misalign_ok | input | 1 | Misaligned partial blocks are allowed |
| wp_hit | input | 1 | Block targets a protected region |
| state | output | 2 | Card state code |
| illegal_cmd | output | 1 | One-cycle pulse for a stop outside receive |
| addr_err | output | 1 | Address-error status bit |
| wp_viol | output | 1 | Write-protect-violation status bit |
| rsp_valid | output | 1 | Status response issued |
| rsp_addr_err | output | 1 | Address-error bit carried in the response |
| rsp_wp_viol | output | 1 | Protect-violation bit carried in the response |
| blk_commit | output | 1 | Block passed on for programming |

## Verification
The assertions assume that a command and a block strobe never arrive in the same cycle with the block expected to count. Under that assumption every `blk_commit` follows a lone block seen in the receive state. They also assume that `blk_len` never goes past `BLK_BYTES`. The bench drives one event per cycle, on the falling edge, with lengths no larger than one block. A scoreboard queue holds every expected response, illegal-command pulse and commit, and a monitor matches them against the outputs one clock later.

// File: rtl/mbw_tracker.sv
module mbw_tracker #(
  parameter int BLK_BYTES = 512,
  parameter int LEN_W     = 10,
  parameter int CNT_W     = 16,
  parameter int BUSY_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_kind,
  input  logic [CNT_W-1:0] cmd_arg,
  input  logic             blk_valid,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             misalign_ok,
  input  logic             wp_hit,
  output logic [1:0]       state,
  output logic             illegal_cmd,
  output logic             addr_err,
  output logic             wp_viol,
  output logic             rsp_valid,
  output logic             rsp_addr_err,
  output logic             rsp_wp_viol,
  output logic             blk_commit
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BSY_W = $clog2(BUSY_CYC + 1);
  localparam int SUM_W = LEN_W + 1;

  localparam logic [2:0] K_SETCNT = 3'd1;
  localparam logic [2:0] K_WRMULT = 3'd2;
  localparam logic [2:0] K_STOP   = 3'd3;
  localparam logic [2:0] K_STATUS = 3'd4;

  localparam logic [1:0] S_TRAN = 2'd0;
  localparam logic [1:0] S_RCV  = 2'd1;
  localparam logic [1:0] S_PRG  = 2'd2;

  localparam logic [BSY_W-1:0] BUSY_LOAD = BSY_W'(BUSY_CYC - 1);

  logic             pend;
  logic [CNT_W-1:0] pend_cnt;
  logic             counted;
  logic [CNT_W-1:0] remain;
  logic [OFF_W-1:0] off;
  logic             halted;
  logic [BSY_W-1:0] busy;

  logic [SUM_W-1:0] sum;
  logic             misaligned;
  logic             blk_take;
  logic             last_blk;

  assign sum        = SUM_W'(off) + SUM_W'(blk_len);
  assign misaligned = !misalign_ok && (off != '0);
  assign blk_take   = !cmd_valid && blk_valid && (state == S_RCV) && !halted;
  assign last_blk   = counted && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_TRAN;
      illegal_cmd  <= 1'b0;
      addr_err     <= 1'b0;
      wp_viol      <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_wp_viol  <= 1'b0;
      blk_commit   <= 1'b0;
      pend         <= 1'b0;
      pend_cnt     <= '0;
      counted      <= 1'b0;
      remain       <= '0;
      off          <= '0;
      halted       <= 1'b0;
      busy         <= '0;
    end else begin
      illegal_cmd <= 1'b0;
      rsp_valid   <= 1'b0;
      blk_commit  <= 1'b0;

      if (state == S_PRG) begin
        if (busy == '0) state <= S_TRAN;
        else            busy  <= busy - 1'b1;
      end

      if (cmd_valid) begin
        pend <= (cmd_kind == K_SETCNT) && (cmd_arg != '0);
        if (cmd_kind == K_SETCNT) pend_cnt <= cmd_arg;
        case (cmd_kind)
          K_WRMULT: if (state == S_TRAN) begin
            state   <= S_RCV;
            counted <= pend;
            remain  <= pend_cnt;
            off     <= '0;
            halted  <= 1'b0;
          end
          K_STOP: if (state == S_RCV) begin
            state        <= S_PRG;
            busy         <= BUSY_LOAD;
            rsp_valid    <= 1'b1;
            rsp_addr_err <= addr_err;
            rsp_wp_viol  <= wp_viol;
            addr_err     <= 1'b0;
            wp_viol      <= 1'b0;
          end else begin
            illegal_cmd <= 1'b1;
          end
          K_STATUS: begin
            rsp_valid    <= 1'b1;
            rsp_addr_err <= addr_err;
            rsp_wp_viol  <= wp_viol;
            addr_err     <= 1'b0;
            wp_viol      <= 1'b0;
          end
          default: ;
        endcase
      end else if (blk_take) begin
        if (misaligned) begin
          addr_err <= 1'b1;
          halted   <= 1'b1;
        end else if (wp_hit) begin
          wp_viol <= 1'b1;
          halted  <= 1'b1;
        end else begin
          blk_commit <= 1'b1;
          off        <= sum[OFF_W-1:0];
          if (counted) remain <= remain - 1'b1;
          if (last_blk) begin
            state <= S_PRG;
            busy  <= BUSY_LOAD;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbw_tracker_chk.sv
module mbw_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       blk_valid,
  input logic [1:0] state,
  input logic       illegal_cmd,
  input logic       addr_err,
  input logic       wp_viol,
  input logic       rsp_valid,
  input logic       blk_commit
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

  p_enter_rcv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd0 && state == 2'd1) |-> $past(cmd_valid && cmd_kind == 3'd2));

  p_prg_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd2 && state != 2'd2) |-> state == 2'd0);

  p_illegal_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> $past(cmd_valid && cmd_kind == 3'd3 && state != 2'd1));

  p_stop_prg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(cmd_kind == 3'd3)) |-> state == 2'd2);

  p_halt_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == 2'd1 && (addr_err || wp_viol)) |-> !blk_commit);

  p_rsp_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!addr_err && !wp_viol));

  p_commit_rcv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |-> $past(state == 2'd1 && blk_valid && !cmd_valid));
endmodule

bind mbw_tracker mbw_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .blk_valid(blk_valid), .state(state), .illegal_cmd(illegal_cmd),
  .addr_err(addr_err), .wp_viol(wp_viol), .rsp_valid(rsp_valid),
  .blk_commit(blk_commit)
);

// File: tb/mbw_tracker_tb.sv
module mbw_tracker_tb;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_kind = 3'd0;
  logic [15:0] cmd_arg = 16'd0;
  logic        blk_valid = 1'b0;
  logic [9:0]  blk_len = 10'd0;
  logic        misalign_ok = 1'b0;
  logic        wp_hit = 1'b0;
  logic [1:0]  state;
  logic        illegal_cmd, addr_err, wp_viol, rsp_valid;
  logic        rsp_addr_err, rsp_wp_viol, blk_commit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  mbw_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_arg(cmd_arg), .blk_valid(blk_valid), .blk_len(blk_len),
    .misalign_ok(misalign_ok), .wp_hit(wp_hit), .state(state),
    .illegal_cmd(illegal_cmd), .addr_err(addr_err), .wp_viol(wp_viol),
    .rsp_valid(rsp_valid), .rsp_addr_err(rsp_addr_err),
    .rsp_wp_viol(rsp_wp_viol), .blk_commit(blk_commit)
  );

  task automatic expect_ev(input logic [3:0] ev, input string tag);
    exp_q.push_back(ev);
    tag_q.push_back(tag);
  endtask

  task automatic got(input logic [3:0] ev);
    logic [3:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event actual=%h expected=none", ev);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e !== ev) begin
        errors++;
        $display("FAIL %s event actual=%h expected=%h", t, ev, e);
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rsp_valid)   got({2'd1, rsp_addr_err, rsp_wp_viol});
      if (illegal_cmd) got(4'b1000);
      if (blk_commit)  got(4'b1100);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] k, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_arg = 16'd0;
  endtask

  task automatic blk(input logic [9:0] len, input logic hit);
    @(negedge clk);
    blk_valid = 1'b1; blk_len = len; wp_hit = hit;
    @(negedge clk);
    blk_valid = 1'b0; blk_len = 10'd0; wp_hit = 1'b0;
  endtask

  task automatic settle(input string tag);
    repeat (BUSY) @(negedge clk);
    chk(tag, state, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state", state, 0);
    chk("R1 flags", {addr_err, wp_viol, rsp_valid, illegal_cmd, blk_commit}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_ev(4'b1000, "R4 stop in transfer");
    cmd(3'd3, 16'd0);
    chk("R4 state kept", state, 0);

    cmd(3'd1, 16'd3);
    cmd(3'd2, 16'd0);
    chk("R2 receive", state, 1);
    for (int i = 0; i < 3; i++) begin
      expect_ev(4'b1100, "R11 counted commit");
      blk(10'd512, 1'b0);
    end
    chk("R3 auto programming", state, 2);
    repeat (BUSY - 1) @(negedge clk);
    chk("R3 still programming", state, 2);
    @(negedge clk);
    chk("R3 back to transfer", state, 0);
    expect_ev(4'b1000, "R4 stop after counted end");
    cmd(3'd3, 16'd0);

    cmd(3'd1, 16'd2);
    cmd(3'd0, 16'd0);
    cmd(3'd2, 16'd0);
    for (int i = 0; i < 4; i++) begin
      expect_ev(4'b1100, "R2 open-ended commit");
      blk(10'd512, 1'b0);
    end
    chk("R5 open-ended stays receive", state, 1);
    expect_ev(4'b0100, "R5 stop response");
    cmd(3'd3, 16'd0);
    chk("R5 stop to programming", state, 2);
    settle("R5 settle");

    cmd(3'd1, 16'd0);
    cmd(3'd2, 16'd0);
    for (int i = 0; i < 2; i++) begin
      expect_ev(4'b1100, "R6 zero-count commit");
      blk(10'd512, 1'b0);
    end
    chk("R6 zero count open-ended", state, 1);
    expect_ev(4'b0100, "R6 stop response");
    cmd(3'd3, 16'd0);
    settle("R6 settle");

    misalign_ok = 1'b0;
    cmd(3'd2, 16'd0);
    expect_ev(4'b1100, "R7 partial commit");
    blk(10'd100, 1'b0);
    blk(10'd512, 1'b0);
    chk("R7 addr_err set", addr_err, 1);
    blk(10'd512, 1'b0);
    chk("R7 stays receive", state, 1);
    expect_ev(4'b0110, "R9 status response");
    cmd(3'd4, 16'd0);
    chk("R9 addr_err cleared", addr_err, 0);
    expect_ev(4'b0100, "R9 stop after cleared");
    cmd(3'd3, 16'd0);
    settle("R7 settle");

    cmd(3'd1, 16'd2);
    cmd(3'd2, 16'd0);
    blk(10'd512, 1'b1);
    chk("R8 wp_viol set", wp_viol, 1);
    blk(10'd512, 1'b0);
    blk(10'd512, 1'b0);
    chk("R8 halted in receive", state, 1);
    expect_ev(4'b0101, "R9 stop carries wp");
    cmd(3'd3, 16'd0);
    chk("R9 wp cleared", wp_viol, 0);
    settle("R8 settle");

    misalign_ok = 1'b1;
    cmd(3'd2, 16'd0);
    expect_ev(4'b1100, "R10 partial 100");
    blk(10'd100, 1'b0);
    expect_ev(4'b1100, "R10 partial 200");
    blk(10'd200, 1'b0);
    expect_ev(4'b1100, "R10 full after partials");
    blk(10'd512, 1'b0);
    chk("R10 no error", addr_err, 0);
    expect_ev(4'b0100, "R10 stop response");
    cmd(3'd3, 16'd0);
    settle("R10 settle");

    repeat (2) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule